// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It walks a page directory and a page table held in system memory. The requester supplies the address, a write flag and a user flag. The block also samples the paging enable, the supervisor write-protect control, the large-page enable and the directory base at the cycle the request is accepted. Only one request is in flight at a time. The walker reads entries through a simple valid/ready memory port and writes back entries whose accessed or dirty marks it had to set.

Each walk ends with a one-cycle `done` strobe. The strobe carries one of two results. A translation gives the physical address, whether the page is 4 MB, and whether writes are permitted. A fault gives a three-bit error code, and the faulting address is captured in a fault-address register. Entry bit positions are fixed: present = bit 0, read/write = bit 1, user = bit 2, accessed = bit 5, dirty = bit 6, page size = bit 7. Frames occupy bits 31:12 of an entry.

Top module: `lin_xlate_walker`

## Requirements
- R1: The directory entry is read from address {base[31:12], 12'h000} + 4 × addr[31:22]. A table entry is read from {pde[31:12], 12'h000} + 4 × addr[21:12].
- R2: When paging is off, the result is the request address with write allowed and a 4 KB size. No memory access is made, and `done` rises in the cycle after acceptance.
- R3: A directory or table entry whose bit 0 is clear ends the walk with a fault, and error bit 0 is 0.
- R4: A user request to an entry with bit 2 clear faults. A user write to an entry with bit 1 clear also faults. In both cases error bit 0 is 1.
- R5: A supervisor write faults (error bit 0 = 1) only if write-protect is on, the entry has bit 2 set and the entry has bit 1 clear. Supervisor reads never fault on protection.
- R6: If the directory entry has bit 7 set and the large-page enable is on, no table is read. The result is {pde[31:22], addr[21:0]}, `big` is 1 and it is not a fault.
- R7: On a 4 KB walk, a directory entry with bit 5 clear is written back with bit 5 set before the table entry is read. If bit 5 is already set, no write happens.
- R8: The final table entry gets bit 5 set, and bit 6 set on a write. It is written back only if that changed it. The 4 KB result is {pte[31:12], addr[11:0]}.
- R9: On any fault, `fault_addr` takes the request address. Error bit 1 equals the write flag and error bit 2 equals the user flag.
- R10: Write permission comes from the final entry. For a user request it equals bit 1. For a supervisor request it is 1 unless write-protect is on, bit 2 is set and bit 1 is clear.
- R11: For a 4 MB page, the directory entry gets bit 5 set, and bit 6 set on a write. It is written back only if that changed it.
- R12: `done` lasts exactly one cycle, and `req_ready` is low from acceptance through `done`. While `mem_valid` waits for `mem_ready`, the address, direction and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken when both high |
| req_addr | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| cfg_paging | input | 1 | Paging enabled |
| cfg_wp | input | 1 | Supervisor write-protect enabled |
| cfg_pse | input | 1 | 4 MB pages enabled |
| cfg_dir_base | input | 32 | Directory base register |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts / returns data this cycle |
| mem_write | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Entry value to write |
| mem_rdata | input | 32 | Entry value read, valid with mem_ready |
| done | output | 1 | Result strobe, one cycle |
| out_fault | output | 1 | Result is a fault |
| out_phys | output | 32 | Physical address |
| out_big | output | 1 | Page is 4 MB |
| out_writable | output | 1 | Writes permitted |
| out_err | output | 3 | Error code {user, write, protection} |
| fault_addr | output | 32 | Address of the last fault |

## Verification
The bench builds the walker with its default split of 12 offset bits and two 10-bit indices. This gives real 4 KB and 4 MB geometry, with a 1024-entry directory and 1024-entry tables. The bench memory covers 16 KB, so the directory and three page tables sit at frames 0 to 3. Any access outside this window marks an address error. Large frames use random upper bits, because they are never read. A memory ready line that stalls at random keeps every entry access waiting for varying numbers of cycles. Random flag combinations cover every protection and accessed/dirty path under both settings of write-protect and of the large-page enable.

// File: rtl/ptw_pkg.sv
// Shared constants and state encoding for the page table walker.
// Assumes a 32-bit entry layout with flags in the low 12 bits.
package ptw_pkg;
    localparam int BIT_P  = 0;   // present
    localparam int BIT_RW = 1;   // writable
    localparam int BIT_US = 2;   // user accessible
    localparam int BIT_A  = 5;   // accessed
    localparam int BIT_D  = 6;   // dirty
    localparam int BIT_PS = 7;   // large page (directory only)

    localparam int ERR_PROT = 0;
    localparam int ERR_WR   = 1;
    localparam int ERR_USR  = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIR_RD,
        S_DIR_WR,
        S_TBL_RD,
        S_TBL_WR,
        S_DONE
    } walk_state_t;
endpackage

// File: rtl/ptw_perm.sv
// Protection check for one directory or table entry.
// Combinational. Assumes the entry is present; the caller handles bit 0.
module ptw_perm
    import ptw_pkg::*;
#(
    parameter int EW = 32
) (
    input  logic [EW-1:0] entry,
    input  logic          is_write,
    input  logic          is_user,
    input  logic          wp_en,
    output logic          prot_fault,
    output logic          may_write
);
    logic rw, us;
    logic unused_hi;

    assign rw = entry[BIT_RW];
    assign us = entry[BIT_US];
    assign unused_hi = ^{entry[EW-1:BIT_US+1], entry[BIT_P]};

    // Decide fault and granted write right from user/supervisor rules.
    always_comb begin
        if (is_user) begin
            prot_fault = !us || (is_write && !rw);
            may_write  = rw;
        end else begin
            prot_fault = wp_en && us && is_write && !rw;
            may_write  = !wp_en || !us || rw;
        end
    end
endmodule

// File: rtl/ptw_flag_upd.sv
// Computes the accessed/dirty-updated copy of an entry.
// Combinational. Reports whether the update changed the entry.
module ptw_flag_upd
    import ptw_pkg::*;
#(
    parameter int EW = 32
) (
    input  logic [EW-1:0] entry,
    input  logic          set_dirty,
    output logic [EW-1:0] new_entry,
    output logic          changed
);
    // Set accessed always, dirty only when requested.
    always_comb begin
        new_entry = entry;
        new_entry[BIT_A] = 1'b1;
        if (set_dirty) begin
            new_entry[BIT_D] = 1'b1;
        end
        changed = (new_entry != entry);
    end
endmodule

// File: rtl/lin_xlate_walker.sv
// Two-level page table walker.
// Takes one request at a time and walks the directory, then the table
// (4 KB pages) or stops at the directory (4 MB pages). Accessed/dirty
// marks are written back in memory when they change. Controls are
// sampled at acceptance. The memory port holds its request until ready,
// and read data is taken in the ready cycle.
module lin_xlate_walker
    import ptw_pkg::*;
#(
    parameter int OFF_W = 12,
    parameter int IDX_W = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [OFF_W+2*IDX_W-1:0]      req_addr,
    input  logic                          req_write,
    input  logic                          req_user,
    input  logic                          cfg_paging,
    input  logic                          cfg_wp,
    input  logic                          cfg_pse,
    input  logic [OFF_W+2*IDX_W-1:0]      cfg_dir_base,
    output logic                          mem_valid,
    input  logic                          mem_ready,
    output logic                          mem_write,
    output logic [OFF_W+2*IDX_W-1:0]      mem_addr,
    output logic [OFF_W+2*IDX_W-1:0]      mem_wdata,
    input  logic [OFF_W+2*IDX_W-1:0]      mem_rdata,
    output logic                          done,
    output logic                          out_fault,
    output logic [OFF_W+2*IDX_W-1:0]      out_phys,
    output logic                          out_big,
    output logic                          out_writable,
    output logic [2:0]                    out_err,
    output logic [OFF_W+2*IDX_W-1:0]      fault_addr
);
    localparam int VA_W    = OFF_W + 2*IDX_W;
    localparam int BIG_OFF = OFF_W + IDX_W;

    walk_state_t      st;
    logic [VA_W-1:0]  a_q;
    logic             w_q, u_q, wp_q, pse_q;
    logic [VA_W-1:0]  ent_addr_q, ent_q, tbl_addr_q;
    logic             to_tbl_q;

    logic [VA_W-1:0]  dir_addr, tbl_addr, upd_entry;
    logic             hs, is_big, want_dirty, upd_changed;
    logic             pm_fault, pm_write;
    logic             unused_base;

    assign unused_base = ^cfg_dir_base[OFF_W-1:0];

    // Entry addresses derived from the request and the directory entry.
    assign dir_addr = {cfg_dir_base[VA_W-1:OFF_W], {OFF_W{1'b0}}}
                    + VA_W'({req_addr[VA_W-1 -: IDX_W], 2'b00});
    assign tbl_addr = {mem_rdata[VA_W-1:OFF_W], {OFF_W{1'b0}}}
                    + VA_W'({a_q[BIG_OFF-1:OFF_W], 2'b00});

    assign hs         = mem_valid && mem_ready;
    assign is_big     = (st == S_DIR_RD) && mem_rdata[BIT_PS] && pse_q;
    assign want_dirty = w_q && ((st == S_TBL_RD) || is_big);

    ptw_perm #(.EW(VA_W)) u_perm (
        .entry      (mem_rdata),
        .is_write   (w_q),
        .is_user    (u_q),
        .wp_en      (wp_q),
        .prot_fault (pm_fault),
        .may_write  (pm_write)
    );

    ptw_flag_upd #(.EW(VA_W)) u_upd (
        .entry     (mem_rdata),
        .set_dirty (want_dirty),
        .new_entry (upd_entry),
        .changed   (upd_changed)
    );

    assign req_ready = (st == S_IDLE);
    assign done      = (st == S_DONE);
    assign mem_valid = (st == S_DIR_RD) || (st == S_DIR_WR) ||
                       (st == S_TBL_RD) || (st == S_TBL_WR);
    assign mem_write = (st == S_DIR_WR) || (st == S_TBL_WR);
    assign mem_addr  = ent_addr_q;
    assign mem_wdata = ent_q;

    // Walk sequencer: accept, read/check entries, write back, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= S_IDLE;
            a_q          <= '0;
            w_q          <= 1'b0;
            u_q          <= 1'b0;
            wp_q         <= 1'b0;
            pse_q        <= 1'b0;
            ent_addr_q   <= '0;
            ent_q        <= '0;
            tbl_addr_q   <= '0;
            to_tbl_q     <= 1'b0;
            out_fault    <= 1'b0;
            out_phys     <= '0;
            out_big      <= 1'b0;
            out_writable <= 1'b0;
            out_err      <= '0;
            fault_addr   <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        a_q          <= req_addr;
                        w_q          <= req_write;
                        u_q          <= req_user;
                        wp_q         <= cfg_wp;
                        pse_q        <= cfg_pse;
                        out_fault    <= 1'b0;
                        out_err      <= '0;
                        out_big      <= 1'b0;
                        ent_addr_q   <= dir_addr;
                        if (cfg_paging) begin
                            st <= S_DIR_RD;
                        end else begin
                            out_phys     <= req_addr;
                            out_writable <= 1'b1;
                            st           <= S_DONE;
                        end
                    end
                end
                S_DIR_RD: begin
                    if (hs) begin
                        if (!mem_rdata[BIT_P] || pm_fault) begin
                            out_fault  <= 1'b1;
                            out_err    <= {u_q, w_q, mem_rdata[BIT_P]};
                            fault_addr <= a_q;
                            st         <= S_DONE;
                        end else if (is_big) begin
                            out_phys     <= {mem_rdata[VA_W-1:BIG_OFF], a_q[BIG_OFF-1:0]};
                            out_big      <= 1'b1;
                            out_writable <= pm_write;
                            to_tbl_q     <= 1'b0;
                            if (upd_changed) begin
                                ent_q <= upd_entry;
                                st    <= S_DIR_WR;
                            end else begin
                                st <= S_DONE;
                            end
                        end else begin
                            tbl_addr_q <= tbl_addr;
                            to_tbl_q   <= 1'b1;
                            if (upd_changed) begin
                                ent_q <= upd_entry;
                                st    <= S_DIR_WR;
                            end else begin
                                ent_addr_q <= tbl_addr;
                                st         <= S_TBL_RD;
                            end
                        end
                    end
                end
                S_DIR_WR: begin
                    if (hs) begin
                        if (to_tbl_q) begin
                            ent_addr_q <= tbl_addr_q;
                            st         <= S_TBL_RD;
                        end else begin
                            st <= S_DONE;
                        end
                    end
                end
                S_TBL_RD: begin
                    if (hs) begin
                        if (!mem_rdata[BIT_P] || pm_fault) begin
                            out_fault  <= 1'b1;
                            out_err    <= {u_q, w_q, mem_rdata[BIT_P]};
                            fault_addr <= a_q;
                            st         <= S_DONE;
                        end else begin
                            out_phys     <= {mem_rdata[VA_W-1:OFF_W], a_q[OFF_W-1:0]};
                            out_writable <= pm_write;
                            if (upd_changed) begin
                                ent_q <= upd_entry;
                                st    <= S_TBL_WR;
                            end else begin
                                st <= S_DONE;
                            end
                        end
                    end
                end
                S_TBL_WR: begin
                    if (hs) begin
                        st <= S_DONE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Result strobe is a single cycle.
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Memory request stays unchanged while it waits for ready.
    p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                    && $stable(mem_write) && $stable(mem_wdata));

    // Any write-back carries the accessed and present marks.
    p_wb_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_write |-> mem_wdata[BIT_A] && mem_wdata[BIT_P]);

    // Unpaged requests finish next cycle without touching memory.
    p_unpaged_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !cfg_paging |=> done && !mem_valid && !out_fault);

    // A fault reports the request address and its access kind.
    p_fault_info_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done && out_fault |-> fault_addr == a_q && out_err[ERR_USR] == u_q
                              && out_err[ERR_WR] == w_q);

    // A large page result is never a fault.
    p_big_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && out_big |-> !out_fault && pse_q);

    // No new request is taken while a walk is running.
    p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready);
endmodule

// File: tb/tb_lin_xlate_walker.sv
// Bench for the page table walker: a 16 KB entry memory with random
// stalls, directed corner cases and seeded random walks, each checked
// against a bench reference model.
module tb_lin_xlate_walker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write, req_user;
    logic [31:0] req_addr, cfg_dir_base;
    logic        cfg_paging, cfg_wp, cfg_pse;
    logic        mem_valid, mem_ready, mem_write;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        done, out_fault, out_big, out_writable;
    logic [31:0] out_phys, fault_addr;
    logic [2:0]  out_err;

    logic [31:0] tmem [0:4095];
    int          rd_cnt, wr_cnt, oob;
    logic [31:0] rd_a0, rd_a1;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    lin_xlate_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_user(req_user),
        .cfg_paging(cfg_paging), .cfg_wp(cfg_wp), .cfg_pse(cfg_pse),
        .cfg_dir_base(cfg_dir_base),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .out_fault(out_fault), .out_phys(out_phys), .out_big(out_big),
        .out_writable(out_writable), .out_err(out_err), .fault_addr(fault_addr)
    );

    assign mem_rdata = tmem[mem_addr[13:2]];

    // Random ready with stalls, changed away from the active edge.
    always @(negedge clk) mem_ready <= ($urandom % 4) != 0;

    // Memory model: apply writes and log read addresses.
    always @(posedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            if (mem_addr[31:14] != 0) oob <= oob + 1;
            if (mem_write) begin
                tmem[mem_addr[13:2]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                if (rd_cnt == 0) rd_a0 <= mem_addr; else rd_a1 <= mem_addr;
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit pfault(logic [31:0] e, bit w, bit u, bit wp);
        if (u) return !e[2] || (w && !e[1]);
        return wp && e[2] && w && !e[1];
    endfunction

    function automatic bit grant(logic [31:0] e, bit u, bit wp);
        if (u) return e[1];
        return !wp || !e[2] || e[1];
    endfunction

    // Expected results, filled by the model.
    bit          x_fault, x_big, x_wr;
    logic [2:0]  x_err;
    logic [31:0] x_phys, x_pde_a, x_pte_a, x_pde_new, x_pte_new;
    int          x_reads, x_writes;
    string       x_tag;

    task automatic model(input logic [31:0] a, input bit w, input bit u,
                         input bit pg, input bit wp, input bit pse, input logic [31:0] base);
        logic [31:0] pde, pte;
        x_fault = 0; x_big = 0; x_wr = 0; x_err = 0; x_phys = 0;
        x_reads = 0; x_writes = 0; x_tag = "R10";
        x_pde_a = {base[31:12], 12'h0} + {20'h0, a[31:22], 2'b00};
        x_pte_a = 0;
        if (!pg) begin
            x_phys = a; x_wr = 1; x_tag = "R2";
            return;
        end
        pde = tmem[x_pde_a[13:2]];
        x_pde_new = pde; x_reads = 1;
        if (!pde[0]) begin
            x_fault = 1; x_err = {u, w, 1'b0}; x_tag = "R3"; return;
        end
        if (pfault(pde, w, u, wp)) begin
            x_fault = 1; x_err = {u, w, 1'b1}; x_tag = u ? "R4" : "R5"; return;
        end
        if (pde[7] && pse) begin
            x_pde_new = pde | 32'h20 | (w ? 32'h40 : 32'h0);
            x_writes = (x_pde_new != pde);
            x_big = 1; x_phys = {pde[31:22], a[21:0]}; x_wr = grant(pde, u, wp);
            x_tag = "R6"; return;
        end
        x_pde_new = pde | 32'h20;
        x_writes = (x_pde_new != pde);
        x_pte_a = {pde[31:12], 12'h0} + {20'h0, a[21:12], 2'b00};
        pte = tmem[x_pte_a[13:2]];
        x_pte_new = pte; x_reads = 2;
        if (!pte[0]) begin
            x_fault = 1; x_err = {u, w, 1'b0}; x_tag = "R3"; return;
        end
        if (pfault(pte, w, u, wp)) begin
            x_fault = 1; x_err = {u, w, 1'b1}; x_tag = u ? "R4" : "R5"; return;
        end
        x_pte_new = pte | 32'h20 | (w ? 32'h40 : 32'h0);
        x_writes += (x_pte_new != pte);
        x_phys = {pte[31:12], a[11:0]}; x_wr = grant(pte, u, wp);
    endtask

    task automatic run(input logic [31:0] a, input bit w, input bit u,
                       input bit pg, input bit wp, input bit pse, input logic [31:0] base);
        int cyc = 0;
        model(a, w, u, pg, wp, pse, base);
        rd_cnt = 0; wr_cnt = 0; oob = 0;
        req_addr = a; req_write = w; req_user = u;
        cfg_paging = pg; cfg_wp = wp; cfg_pse = pse; cfg_dir_base = base;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        if (!pg) chk(done === 1'b1, "R2", "done next cycle", {31'h0, done}, 1);
        else chk(req_ready === 1'b0, "R12", "busy ready", {31'h0, req_ready}, 0);
        while (done !== 1'b1 && cyc < 500) begin
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 500) begin
            chk(0, "R12", "watchdog expired", cyc, 0);
            return;
        end
        chk(out_fault === x_fault, x_tag, "fault flag", {31'h0, out_fault}, {31'h0, x_fault});
        if (x_fault) begin
            chk(out_err === x_err, x_tag, "error code", {29'h0, out_err}, {29'h0, x_err});
            chk(fault_addr === a, "R9", "fault address", fault_addr, a);
        end else begin
            chk(out_phys === x_phys, x_big ? "R6" : "R8", "physical address", out_phys, x_phys);
            chk(out_big === x_big, "R6", "page size", {31'h0, out_big}, {31'h0, x_big});
            chk(out_writable === x_wr, x_tag, "write permission", {31'h0, out_writable}, {31'h0, x_wr});
        end
        chk(rd_cnt == x_reads, "R1", "read count", rd_cnt, x_reads);
        chk(wr_cnt == x_writes, x_big ? "R11" : "R7", "write count", wr_cnt, x_writes);
        chk(oob == 0, "R1", "access outside table window", oob, 0);
        if (x_reads >= 1) begin
            chk(rd_a0 === x_pde_a, "R1", "directory entry address", rd_a0, x_pde_a);
            chk(tmem[x_pde_a[13:2]] === x_pde_new, x_big ? "R11" : "R7", "directory entry after walk",
                tmem[x_pde_a[13:2]], x_pde_new);
        end
        if (x_reads == 2) begin
            chk(rd_a1 === x_pte_a, "R1", "table entry address", rd_a1, x_pte_a);
            chk(tmem[x_pte_a[13:2]] === x_pte_new, "R8", "table entry after walk",
                tmem[x_pte_a[13:2]], x_pte_new);
        end
        @(negedge clk);
        chk(done === 1'b0, "R12", "done single cycle", {31'h0, done}, 0);
    endtask

    // Place a directory entry and optionally a table entry for address a.
    task automatic place(input logic [31:0] a, input logic [31:0] base,
                         input logic [31:0] pde, input logic [31:0] pte, input bit has_tbl);
        logic [31:0] pa, ta;
        pa = {base[31:12], 12'h0} + {20'h0, a[31:22], 2'b00};
        tmem[pa[13:2]] = pde;
        if (has_tbl) begin
            ta = {pde[31:12], 12'h0} + {20'h0, a[21:12], 2'b00};
            tmem[ta[13:2]] = pte;
        end
    endtask

    initial begin
        logic [31:0] a, base, pde, pte;
        bit w, u, wp, pse, ps, ok;
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 4096; i++) tmem[i] = 0;
        rst_n = 0; req_valid = 0; req_addr = 0; req_write = 0; req_user = 0;
        cfg_paging = 0; cfg_wp = 0; cfg_pse = 0; cfg_dir_base = 0;
        rd_cnt = 0; wr_cnt = 0; oob = 0; rd_a0 = 0; rd_a1 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(done === 1'b0 && req_ready === 1'b1, "R12", "reset handshake",
            {30'h0, done, req_ready}, 32'h1);
        chk(mem_valid === 1'b0, "R12", "reset memory idle", {31'h0, mem_valid}, 0);
        chk(fault_addr === 0, "R9", "reset fault address", fault_addr, 0);

        // Directed: paging off.
        run(32'hDEAD_BEEF, 1, 1, 0, 1, 1, 32'h0);
        // Directed: directory not present (R3).
        a = 32'h0040_1234;
        place(a, 32'h0, 32'h0000_1006, 0, 0);
        run(a, 1, 1, 1, 0, 0, 32'h0);
        // Directed: table not present (R3), directory gains accessed (R7).
        place(a, 32'h0, 32'h0000_1007, 32'h1234_5006, 1);
        run(a, 0, 0, 1, 0, 0, 32'h0);
        // Directed: user read of supervisor page (R4).
        place(a, 32'h0, 32'h0000_1027, 32'h1234_5023, 1);
        run(a, 0, 1, 1, 0, 0, 32'h0);
        // Directed: user write to read-only page (R4).
        place(a, 32'h0, 32'h0000_1027, 32'h1234_5025, 1);
        run(a, 1, 1, 1, 0, 0, 32'h0);
        // Directed: supervisor write, wp on, user read-only (R5 fault).
        run(a, 1, 0, 1, 1, 0, 32'h0);
        // Directed: same with wp off: allowed and writable (R5, R10), dirty set (R8).
        run(a, 1, 0, 1, 0, 0, 32'h0);
        // Directed: accessed and dirty already set: no writes (R7, R8).
        place(a, 32'h0, 32'h0000_2027, 32'h7777_7067, 1);
        run(a, 1, 1, 1, 1, 0, 32'h0);
        // Directed: 4 MB page (R6, R11).
        a = 32'hFFC3_2100;
        place(a, 32'h0000_0ABC, 32'hABC5_5087, 0, 0);
        run(a, 1, 1, 1, 1, 1, 32'h0000_0ABC);
        // Directed: size bit with extension off walks a table (R6).
        place(a, 32'h0000_0ABC, 32'h0000_3087, 32'h0BAD_0003, 1);
        run(a, 0, 1, 1, 0, 0, 32'h0000_0ABC);

        // Random walks.
        for (int n = 0; n < 400; n++) begin
            a = $urandom; w = $urandom % 2; u = $urandom % 2;
            wp = $urandom % 2; pse = $urandom % 2; ps = ($urandom % 3) == 0;
            base = {20'h0, 12'($urandom)};
            pde = $urandom;
            if (!(ps && pse)) pde[31:12] = 20'(1 + $urandom % 3);
            pde[7] = ps;
            pde[0] = ($urandom % 8) != 0;
            pte = $urandom;
            pte[0] = ($urandom % 8) != 0;
            ok = !(ps && pse);
            place(a, base, pde, pte, ok);
            run(a, w, u, ($urandom % 10) != 0, wp, pse, base);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule